// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block keeps wall time as a single 32-bit count of seconds and raises an interrupt when that count reaches a programmed alarm value. The counter, the alarm compare and the interrupt logic sit in a slow, always-on clock domain. The counter advances once on every slow-clock edge where the one-second `tick` input is high. Software reaches the block through a simple register bus on the fast system clock. Every register is 32 bits wide at a word-aligned byte offset.

Each bus write that must reach the slow domain travels over one request/acknowledge toggle channel. Such writes are set-time, alarm, mask, event-clear and force. While a command is in flight, `bus_busy` is high and further writes are dropped. A free-running toggle handshake moves the running count into the bus domain. It captures the whole 32-bit word into a snapshot register, so the current-time register never returns a torn value. The validity flag, the event flag and the interrupt line come back through two-flop synchronisers.

Software loads the time once, which marks the time valid. It then programs an alarm, enables the interrupt, and acknowledges each alarm by clearing the event bit. Because the line is released only some slow cycles after the acknowledge, software also clears the mask.

Top module: `rtc_secs_top`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low. The readable registers are the alarm (0x00), validity (0x08), current time (0x0C), event (0x10) and mask (0x14).
- R2: A write to offset 0x04 loads the seconds counter with the written value. Each later slow-clock edge with `tick` high adds one, wrapping from 0xFFFFFFFF to 0. Offset 0x0C returns the count as a complete word.
- R3: Bit 0 of offset 0x08 reads 0 until the first set-time write has taken effect. From then on it reads 1.
- R4: Offset 0x00 reads back the written alarm value. Event bit 0 at offset 0x10 is set on the slow edge after the count first becomes equal to the alarm. The count staying at that value does not set it again.
- R5: Writing 0x10 with bit 0 = 1 clears the event bit. Writing it with bit 0 = 0 leaves the event bit unchanged.
- R6: Writing offset 0x18 with bit 0 = 1 sets the event bit as if a match had occurred.
- R7: Bit 0 of offset 0x14 is the interrupt enable and reads back as written. `irq` follows the AND of the event and enable bits after the crossing delay. Clearing either bit drops `irq`.
- R8: When a set-time command lands in a slow cycle that also carries a tick, the loaded value wins for that cycle. An alarm equal to the loaded value therefore fires.
- R9: While `bus_busy` is high, bus writes are dropped. Writes to the read-only offsets 0x08 and 0x0C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Slow always-on clock |
| tick | input | 1 | One-second advance enable, sampled on slow_clk |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| bus_busy | output | 1 | A command is crossing; writes are dropped |
| irq | output | 1 | Alarm interrupt, synchronised to clk |

## Verification
The collision that can happen is a set-time command and a one-second tick landing on the same slow-clock edge. The bench provokes it by holding `tick` high on every slow cycle while the set-time write crosses, so the load has to land on a ticking cycle. The alarm is programmed beforehand to the value being loaded. The event bit can only rise if the loaded value was actually present in the counter for one cycle, so a set event bit shows that the load won over the tick. A current time a little above the loaded value confirms that counting resumed afterwards.

// File: rtl/rtc_secs_pkg.sv
package rtc_secs_pkg;

  localparam int TIME_W = 32;

  localparam logic [7:0] OFS_ALARM = 8'h00;
  localparam logic [7:0] OFS_SET   = 8'h04;
  localparam logic [7:0] OFS_VALID = 8'h08;
  localparam logic [7:0] OFS_TIME  = 8'h0C;
  localparam logic [7:0] OFS_EVENT = 8'h10;
  localparam logic [7:0] OFS_MASK  = 8'h14;
  localparam logic [7:0] OFS_FORCE = 8'h18;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_SET_TIME,
    CMD_ALARM,
    CMD_EV_CLR,
    CMD_FORCE,
    CMD_MASK
  } cmd_e;

  // Map a bus write to the command it sends to the slow domain.
  function automatic cmd_e write_cmd(input logic [7:0] ofs, input logic b0);
    case (ofs)
      OFS_ALARM: return CMD_ALARM;
      OFS_SET:   return CMD_SET_TIME;
      OFS_EVENT: return b0 ? CMD_EV_CLR : CMD_NONE;
      OFS_MASK:  return CMD_MASK;
      OFS_FORCE: return b0 ? CMD_FORCE : CMD_NONE;
      default:   return CMD_NONE;
    endcase
  endfunction

  // One second later, modulo 2**TIME_W.
  function automatic logic [TIME_W-1:0] bump(input logic [TIME_W-1:0] c);
    return c + {{(TIME_W-1){1'b0}}, 1'b1};
  endfunction

  // Event flag update: a new cause wins over a clear in the same cycle.
  function automatic logic ev_next(input logic cur, input logic rise,
                                   input logic frc, input logic clr);
    if (rise || frc) return 1'b1;
    if (clr)         return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rtc_bus_side.sv
module rtc_bus_side
  import rtc_secs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TIME_W-1:0] bus_wdata,
  output logic [TIME_W-1:0] bus_rdata,
  output logic              bus_busy,
  // command channel towards the slow domain
  output logic              req_tgl,
  output cmd_e              req_cmd,
  output logic [TIME_W-1:0] req_data,
  input  logic              ack_s,
  // time snapshot channel from the slow domain
  input  logic              pub_flag_s,
  input  logic [TIME_W-1:0] pub_data,
  output logic              snap_ack,
  // synchronised status
  input  logic              valid_s,
  input  logic              event_s
);
  localparam logic [TIME_W-2:0] HI_ZERO = '0;

  logic [7:0]        ofs;
  cmd_e              wcmd;
  logic              launch;
  logic              wr_attempt;
  logic              snap_take;
  logic [TIME_W-1:0] alarm_sh;
  logic              mask_sh;
  logic [TIME_W-1:0] time_snap;

  assign ofs        = 8'(bus_addr);
  assign wcmd       = write_cmd(ofs, bus_wdata[0]);
  assign bus_busy   = (req_tgl != ack_s);
  assign wr_attempt = bus_sel && bus_wr;
  assign launch     = wr_attempt && !bus_busy && (wcmd != CMD_NONE);
  assign snap_take  = (pub_flag_s != snap_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      req_cmd   <= CMD_NONE;
      req_data  <= '0;
      alarm_sh  <= '0;
      mask_sh   <= 1'b0;
      time_snap <= '0;
      snap_ack  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (launch) begin
        req_tgl  <= ~req_tgl;
        req_cmd  <= wcmd;
        req_data <= bus_wdata;
        if (wcmd == CMD_ALARM) alarm_sh <= bus_wdata;
        if (wcmd == CMD_MASK)  mask_sh  <= bus_wdata[0];
      end
      if (snap_take) begin
        time_snap <= pub_data;
        snap_ack  <= pub_flag_s;
      end
      if (bus_sel && !bus_wr) begin
        case (ofs)
          OFS_ALARM: bus_rdata <= alarm_sh;
          OFS_VALID: bus_rdata <= {HI_ZERO, valid_s};
          OFS_TIME:  bus_rdata <= time_snap;
          OFS_EVENT: bus_rdata <= {HI_ZERO, event_s};
          OFS_MASK:  bus_rdata <= {HI_ZERO, mask_sh};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // A write offered while busy must not start a new crossing.
  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_attempt && bus_busy) |=> $stable(req_tgl));

  // An accepted command keeps the channel busy until acknowledged.
  assert_launch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> bus_busy);

  // The snapshot register only moves on a published handshake step.
  assert_snap_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(time_snap));

endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_secs_pkg::*;
(
  input  logic              slow_clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_tgl_s,
  input  cmd_e              req_cmd,
  input  logic [TIME_W-1:0] req_data,
  output logic              ack_tgl,
  input  logic              snap_ack_s,
  output logic              pub_flag,
  output logic [TIME_W-1:0] pub_data,
  output logic              valid_q,
  output logic              event_q,
  output logic              irq_q
);
  logic [TIME_W-1:0] count;
  logic [TIME_W-1:0] alarm;
  logic              mask_q;
  logic              match_q;

  // named internal events
  logic cmd_fire;
  logic set_fire;
  logic clr_fire;
  logic force_fire;
  logic match_now;
  logic match_rise;
  logic pub_step;

  assign cmd_fire   = (req_tgl_s != ack_tgl);
  assign set_fire   = cmd_fire && (req_cmd == CMD_SET_TIME);
  assign clr_fire   = cmd_fire && (req_cmd == CMD_EV_CLR);
  assign force_fire = cmd_fire && (req_cmd == CMD_FORCE);
  assign match_now  = (count == alarm);
  assign match_rise = match_now && !match_q;
  assign pub_step   = (snap_ack_s == pub_flag);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      alarm    <= '0;
      valid_q  <= 1'b0;
      mask_q   <= 1'b0;
      event_q  <= 1'b0;
      match_q  <= 1'b1;
      irq_q    <= 1'b0;
      ack_tgl  <= 1'b0;
      pub_flag <= 1'b0;
      pub_data <= '0;
    end else begin
      if (set_fire)  count <= req_data;
      else if (tick) count <= bump(count);
      if (set_fire) valid_q <= 1'b1;
      if (cmd_fire && req_cmd == CMD_ALARM) alarm  <= req_data;
      if (cmd_fire && req_cmd == CMD_MASK)  mask_q <= req_data[0];
      if (cmd_fire) ack_tgl <= req_tgl_s;
      match_q <= match_now;
      event_q <= ev_next(event_q, match_rise, force_fire, clr_fire);
      irq_q   <= event_q && mask_q;
      if (pub_step) begin
        pub_data <= count;
        pub_flag <= ~pub_flag;
      end
    end
  end

  assert_set_loads_R2: assert property (@(posedge slow_clk) disable iff (!rst_n)
    set_fire |=> (count == $past(req_data)));

  assert_tick_step_R2: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (tick && !set_fire) |=> (count == bump($past(count))));

  assert_valid_sticky_R3: assert property (@(posedge slow_clk) disable iff (!rst_n)
    valid_q |=> valid_q);

  assert_event_cause_R4: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(event_q) |-> $past(match_rise || force_fire));

  assert_event_clear_R5: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (clr_fire && !match_rise && !force_fire) |=> !event_q);

  assert_irq_gate_R7: assert property (@(posedge slow_clk) disable iff (!rst_n)
    irq_q |-> $past(event_q && mask_q));

endmodule

// File: rtl/rtc_secs_top.sv
module rtc_secs_top
  import rtc_secs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_busy,
  output logic              irq
);
  logic              req_tgl;
  logic              req_tgl_s;
  cmd_e              req_cmd;
  logic [TIME_W-1:0] req_data;
  logic              ack_tgl;
  logic              ack_s;
  logic              pub_flag;
  logic              pub_flag_s;
  logic [TIME_W-1:0] pub_data;
  logic              snap_ack;
  logic              snap_ack_s;
  logic              valid_q;
  logic              event_q;
  logic              irq_q;
  logic [2:0]        stat_s;

  rtc_bus_side #(.ADDR_W(ADDR_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_busy   (bus_busy),
    .req_tgl    (req_tgl),
    .req_cmd    (req_cmd),
    .req_data   (req_data),
    .ack_s      (ack_s),
    .pub_flag_s (pub_flag_s),
    .pub_data   (pub_data),
    .snap_ack   (snap_ack),
    .valid_s    (stat_s[0]),
    .event_s    (stat_s[1])
  );

  rtc_slow_core u_core (
    .slow_clk   (slow_clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .req_tgl_s  (req_tgl_s),
    .req_cmd    (req_cmd),
    .req_data   (req_data),
    .ack_tgl    (ack_tgl),
    .snap_ack_s (snap_ack_s),
    .pub_flag   (pub_flag),
    .pub_data   (pub_data),
    .valid_q    (valid_q),
    .event_q    (event_q),
    .irq_q      (irq_q)
  );

  // bus -> slow
  rtc_sync2 #(.W(2)) u_to_slow (
    .clk   (slow_clk),
    .rst_n (rst_n),
    .d     ({snap_ack, req_tgl}),
    .q     ({snap_ack_s, req_tgl_s})
  );

  // slow -> bus
  rtc_sync2 #(.W(2)) u_hs_to_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pub_flag, ack_tgl}),
    .q     ({pub_flag_s, ack_s})
  );

  rtc_sync2 #(.W(3)) u_stat_to_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({irq_q, event_q, valid_q}),
    .q     (stat_s)
  );

  assign irq = stat_s[2];

endmodule

// File: tb/test_rtc_secs_top.sv
module test_rtc_secs_top;

  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_busy;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;        // 100 MHz
  always #35 slow_clk = ~slow_clk;

  rtc_secs_top i_rtc_secs_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_clk  (slow_clk),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_busy  (bus_busy),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (bus_busy) @(negedge clk);
  endtask

  task automatic settle();
    wait_idle();
    repeat (20) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    wait_idle();
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge slow_clk);
    tick = 1'b1;
    repeat (n) @(negedge slow_clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(5'h00, v); chk("R1 alarm", v, 0);
    bus_read(5'h08, v); chk("R1 valid", v, 0);
    bus_read(5'h0C, v); chk("R1 time", v, 0);
    bus_read(5'h10, v); chk("R1 event", v, 0);
    bus_read(5'h14, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_set_time();
    logic [31:0] v;
    bus_write(5'h04, 32'd1000); settle();
    bus_read(5'h0C, v); chk("R2 loaded", v, 1000);
    bus_read(5'h08, v); chk("R3 valid after set", v, 1);
    ticks(5); settle();
    bus_read(5'h0C, v); chk("R2 five ticks", v, 1005);
    bus_write(5'h0C, 32'd7); settle();
    bus_read(5'h0C, v); chk("R9 time read-only", v, 1005);
    bus_write(5'h08, 32'd0); settle();
    bus_read(5'h08, v); chk("R9 valid read-only", v, 1);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    bus_write(5'h04, 32'd50);
    bus_write(5'h00, 32'd53); settle();
    bus_read(5'h00, v); chk("R4 alarm readback", v, 53);
    bus_read(5'h10, v); chk("R4 no early event", v, 0);
    ticks(3); settle();
    bus_read(5'h0C, v); chk("R4 count at alarm", v, 53);
    bus_read(5'h10, v); chk("R4 event on match", v, 1);
    bus_write(5'h10, 32'd1); settle();
    bus_read(5'h10, v); chk("R5 cleared, R4 no retrigger", v, 0);
    bus_write(5'h18, 32'd1); settle();
    bus_read(5'h10, v); chk("R6 force", v, 1);
    bus_write(5'h10, 32'd0); settle();
    bus_read(5'h10, v); chk("R5 zero write ignored", v, 1);
    bus_write(5'h10, 32'd1); settle();
    bus_read(5'h10, v); chk("R5 clear after force", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bus_write(5'h14, 32'd1); settle();
    bus_read(5'h14, v); chk("R7 mask readback", v, 1);
    chk("R7 no event no irq", {31'b0, irq}, 0);
    bus_write(5'h18, 32'd1); settle();
    chk("R7 irq raised", {31'b0, irq}, 1);
    bus_write(5'h10, 32'd1); settle();
    chk("R7 irq dropped by clear", {31'b0, irq}, 0);
    bus_write(5'h18, 32'd1); settle();
    chk("R7 irq raised again", {31'b0, irq}, 1);
    bus_write(5'h14, 32'd0); settle();
    chk("R7 irq dropped by mask", {31'b0, irq}, 0);
    bus_read(5'h14, v); chk("R7 mask cleared", v, 0);
    bus_write(5'h10, 32'd1); settle();
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wait_idle();
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'd111;
    @(negedge clk);
    chk("R9 busy after write", {31'b0, bus_busy}, 1);
    bus_wdata = 32'd222;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    settle();
    bus_read(5'h00, v); chk("R9 busy write dropped", v, 111);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    bus_write(5'h00, 32'd900); settle();
    bus_read(5'h10, v); chk("R8 event clear before", v, 0);
    @(negedge slow_clk);
    tick = 1'b1;
    bus_write(5'h04, 32'd900);
    settle();
    @(negedge slow_clk);
    tick = 1'b0;
    settle();
    bus_read(5'h10, v); chk("R8 load wins over tick", v, 1);
    bus_read(5'h0C, v);
    chk("R8 counting resumed", {31'b0, (v > 32'd900) && (v < 32'd1200)}, 1);
    bus_write(5'h10, 32'd1); settle();
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bus_write(5'h04, 32'hFFFF_FFFF); settle();
    bus_read(5'h0C, v); chk("R2 max value", v, 32'hFFFF_FFFF);
    ticks(2); settle();
    bus_read(5'h0C, v); chk("R2 wrap", v, 1);
  endtask

  initial begin
    fork
      begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(posedge slow_clk);
    @(negedge clk);
    t_reset();
    t_set_time();
    t_alarm();
    t_irq();
    t_busy();
    t_collide();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule